// File: doc/BRIEF.md
# SONET A1/A2 Frame Boundary Detector

This block sits behind a deserializer whose bytes are already word-aligned. It watches the strobed byte stream for the framing run: two A1 bytes (0xF6), then three A2 bytes (0x28). It re-emits the stream two byte slots late, so that it can see the whole run before it marks it. It raises a frame pulse that lasts exactly one byte period. The pulse starts in the byte period after the first A2 of the run appears on the delayed output, which is the same period in which the second A2 appears there.

The block also holds a hunt-enable flag for the bit-level boundary hunter. A rising edge on the arm input sets the flag. The first frame pulse clears it. Recognition does not depend on that flag: every aligned framing run produces a pulse. A system can therefore treat a missing pulse at the expected frame time as loss of frame, and then arm the hunt again.

Top module: `frame_boundary_detector`

## Requirements
- R1: The framing run is five consecutive strobed bytes in arrival order: 0xF6, 0xF6, 0x28, 0x28, 0x28. Only this run produces a frame pulse, and leading extra 0xF6 bytes do not prevent it.
- R2: `framePulse` rises on the clock edge of the first strobe after the strobe that completed the run. It falls on the clock edge of the next strobe after that, so it is high for exactly one byte period.
- R3: `dataOut` holds the byte accepted two strobes earlier than the most recent strobe. While `framePulse` is high, `dataOut` shows the second A2 of the run.
- R4: Clock cycles without `byteValid` change neither `dataOut` nor `framePulse`. A pulse therefore stays high across idle cycles until the next strobe.
- R5: A byte that does not fit the run breaks a partial match, and a new match must begin again from A1. Examples that produce no pulse: A1,A1,A2,x,A2,A2 with x not equal to A2; a single A1 followed by three A2; A1,A1,A2,A2,A1.
- R6: Reset clears the byte history, `dataOut`, `framePulse`, `strobeOut` and `huntActive`. A run that was partly received before reset produces no pulse when it is completed after reset.
- R7: A 0-to-1 transition of `huntArm` sets `huntActive` on the following clock edge. `huntActive` then stays high until the clock edge on which `framePulse` rises, and it clears on that edge.
- R8: Recognition repeats for every framing run whether `huntActive` is high or low. No re-arming is needed.
- R9: If a rising edge of `huntArm` falls in the same cycle as the edge that raises `framePulse`, `huntActive` ends up high.
- R10: `strobeOut` equals `byteValid` delayed by one clock. It marks the cycle in which a new `dataOut` and `framePulse` value first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Strobe: `byteIn` carries a new byte this cycle |
| byteIn | input | 8 | Aligned byte from the deserializer, first serial bit in bit 7 |
| huntArm | input | 1 | A rising edge arms the boundary hunt |
| dataOut | output | 8 | Byte stream delayed by two byte slots |
| strobeOut | output | 1 | `byteValid` delayed by one clock |
| framePulse | output | 1 | One-byte-period pulse marking the A1/A2 boundary |
| huntActive | output | 1 | High while the boundary hunter may keep searching |

## Verification
Two functions can meet in the same cycle: the arm edge from `huntArm` and the hunt stop caused by a rising frame pulse. The bench provokes this by raising `huntArm` in the same cycle as the strobe that follows a complete framing run. It then requires `huntActive` to be high, and the frame pulse must still be delivered with its usual timing. In a separate case, arming without a collision followed by a pulse must leave `huntActive` low. This shows that the stop path works on its own, so the collision result is not just a stuck-high flag.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;    // accept byteIn into the history
    logic compareEn;  // history is completely filled since reset
  } fbdCtl_t;
endpackage

// File: rtl/fbd_datapath.sv
module fbd_datapath
  import fbd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int A1_CNT = 2,
  parameter int A2_CNT = 3,
  parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fbdCtl_t           ctl,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              patternHit
);
  localparam int SEQ_LEN = A1_CNT + A2_CNT;
  // index 0 holds the newest byte; the first A2 of a run sits at A2_CNT-1
  localparam int TAP = A2_CNT - 1;

  logic [BYTE_W-1:0] hist [SEQ_LEN];
  logic [SEQ_LEN-1:0] stageHit;

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_stage
    localparam logic [BYTE_W-1:0] EXP_CODE = (i < A2_CNT) ? A2_CODE : A1_CODE;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)           hist[i] <= '0;
        else if (ctl.shiftEn) hist[i] <= byteIn;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)           hist[i] <= '0;
        else if (ctl.shiftEn) hist[i] <= hist[i-1];
      end
    end
    assign stageHit[i] = (hist[i] == EXP_CODE);
  end

  assign patternHit = ctl.compareEn & (&stageHit);
  assign dataOut    = hist[TAP];
endmodule

// File: rtl/fbd_control.sv
module fbd_control
  import fbd_pkg::*;
#(
  parameter int SEQ_LEN = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byteValid,
  input  logic    huntArm,
  input  logic    patternHit,
  output fbdCtl_t ctl,
  output logic    strobeOut,
  output logic    framePulse,
  output logic    huntActive
);
  localparam int CNT_W = $clog2(SEQ_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SEQ_LEN);

  logic [CNT_W-1:0] fillCnt;
  logic armPrev;
  logic armEdge;
  logic pulseSet;

  assign armEdge  = huntArm & ~armPrev;
  assign pulseSet = byteValid & patternHit;

  assign ctl.shiftEn   = byteValid;
  assign ctl.compareEn = (fillCnt == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fillCnt    <= '0;
      armPrev    <= 1'b0;
      strobeOut  <= 1'b0;
      framePulse <= 1'b0;
      huntActive <= 1'b0;
    end else begin
      armPrev   <= huntArm;
      strobeOut <= byteValid;
      if (byteValid && fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
      if (byteValid) framePulse <= patternHit;
      // a fresh arm request outranks the stop caused by a pulse
      if (armEdge)       huntActive <= 1'b1;
      else if (pulseSet) huntActive <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_boundary_detector.sv
module frame_boundary_detector
  import fbd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int A1_CNT = 2,
  parameter int A2_CNT = 3,
  parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              huntArm,
  output logic [BYTE_W-1:0] dataOut,
  output logic              strobeOut,
  output logic              framePulse,
  output logic              huntActive
);
  localparam int SEQ_LEN = A1_CNT + A2_CNT;

  fbdCtl_t ctl;
  logic    patternHit;

  fbd_datapath #(
    .BYTE_W(BYTE_W), .A1_CNT(A1_CNT), .A2_CNT(A2_CNT),
    .A1_CODE(A1_CODE), .A2_CODE(A2_CODE)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .byteIn(byteIn),
    .dataOut(dataOut), .patternHit(patternHit)
  );

  fbd_control #(.SEQ_LEN(SEQ_LEN)) u_control (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .huntArm(huntArm),
    .patternHit(patternHit), .ctl(ctl), .strobeOut(strobeOut),
    .framePulse(framePulse), .huntActive(huntActive)
  );
endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byteValid,
  input logic              huntArm,
  input logic [BYTE_W-1:0] dataOut,
  input logic              strobeOut,
  input logic              framePulse,
  input logic              huntActive
);
  // R2
  pulse_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (framePulse && byteValid) |=> !framePulse);
  // R2
  pulse_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framePulse) |-> $past(byteValid));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> ($stable(dataOut) && $stable(framePulse)));
  // R10
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |=> strobeOut);
  // R10
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> !strobeOut);
  // R7
  hunt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(huntActive) |-> $rose(framePulse));
  // R7
  hunt_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(huntActive) |-> ($past(huntArm) && !$past(huntArm, 2)));
endmodule

bind frame_boundary_detector fbd_checker #(.BYTE_W(BYTE_W)) u_fbd_checker (
  .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .huntArm(huntArm),
  .dataOut(dataOut), .strobeOut(strobeOut), .framePulse(framePulse),
  .huntActive(huntActive)
);

// File: tb/frame_boundary_detector_bench.sv
module frame_boundary_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;

  typedef struct { logic [7:0] d; logic p; } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic huntArm = 1'b0;
  logic [7:0] dataOut;
  logic strobeOut, framePulse, huntActive;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";
  expItem_t expQ[$];
  logic [7:0] mh [5];
  int mcnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_boundary_detector u_frame_boundary_detector (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteIn(byteIn),
    .huntArm(huntArm), .dataOut(dataOut), .strobeOut(strobeOut),
    .framePulse(framePulse), .huntActive(huntActive)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < 5; i++) mh[i] = '0;
    mcnt = 0;
  endtask

  // driver: one strobed byte, expected result queued for the monitor
  task automatic sendByte(input logic [7:0] b, input int gap = 0, input bit arm = 1'b0);
    expItem_t it;
    @(negedge clk);
    byteValid = 1'b1; byteIn = b; huntArm = arm;
    it.p = (mcnt >= 5) && mh[4] == A1 && mh[3] == A1 &&
           mh[2] == A2 && mh[1] == A2 && mh[0] == A2;
    for (int i = 4; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = b;
    mcnt++;
    it.d = mh[2];
    expQ.push_back(it);
    @(negedge clk);
    byteValid = 1'b0; huntArm = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendRun();
    sendByte(A1); sendByte(A1); sendByte(A2); sendByte(A2); sendByte(A2);
  endtask

  task automatic armHunt();
    @(negedge clk); huntArm = 1'b1;
    @(negedge clk); huntArm = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    modelClear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compares each new output slot with the queued expectation
  always @(negedge clk) begin
    if (rst_n && strobeOut) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected strobeOut", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({curTag, " framePulse"}, framePulse, e.p);
        check("R3 dataOut", dataOut, e.d);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 dataOut", dataOut, 8'h00);
    check("R6 framePulse", framePulse, 0);
    check("R6 huntActive", huntActive, 0);
    check("R6 strobeOut", strobeOut, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: arm then stop on first pulse
    armHunt();
    check("R7 armed", huntActive, 1);
    curTag = "R1";
    sendByte(8'h00);
    sendRun();
    check("R7 still armed before pulse", huntActive, 1);
    // R4: pulse holds across idle cycles
    sendByte(8'h11, 3);
    check("R4 pulse held in gap", framePulse, 1);
    check("R4 dataOut held in gap", dataOut, A2);
    check("R10 strobeOut idle", strobeOut, 0);
    check("R7 stopped by pulse", huntActive, 0);
    sendByte(8'h22, 2);
    check("R2 pulse ended", framePulse, 0);

    // R8: repeats with hunt off
    curTag = "R8";
    sendRun(); sendByte(8'h33); sendByte(8'h44);
    check("R8 hunt stays off", huntActive, 0);

    // R5: broken partial matches
    curTag = "R5";
    sendByte(A1); sendByte(A1); sendByte(A2); sendByte(8'h55);
    sendByte(A2); sendByte(A2); sendByte(A2); sendByte(8'h00);
    sendByte(A1); sendByte(A2); sendByte(A2); sendByte(A2); sendByte(8'h00);
    sendByte(A1); sendByte(A1); sendByte(A2); sendByte(A2); sendByte(A1); sendByte(8'h00);
    curTag = "R1";
    sendByte(A1); sendRun(); sendByte(8'h66); sendByte(8'h77);

    // R9: arm edge in the same cycle as the pulse rising
    curTag = "R9";
    sendRun();
    sendByte(8'h88, 0, 1'b1);
    check("R9 arm wins", huntActive, 1);
    sendByte(8'h99);
    check("R9 still armed", huntActive, 1);

    // R6: partial run before reset must not complete after it
    curTag = "R6";
    sendByte(A1); sendByte(A1); sendByte(A2); sendByte(A2);
    repeat (2) @(negedge clk);
    doReset();
    check("R6 dataOut after reset", dataOut, 8'h00);
    check("R6 hunt after reset", huntActive, 0);
    sendByte(A2); sendByte(8'h12); sendByte(8'h34); sendByte(8'h56);

    repeat (4) @(negedge clk);
    check("R10 all slots delivered", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule